// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block translates a virtual page number into a physical frame by searching a hashed page table held in memory. A request carries a VPN. The block folds the VPN into a bucket index and reads that bucket's head pointer. It then follows a singly linked chain of elements. At each element it compares the stored tag against the requested one. It stops on a match, at the end of the chain, or when a step cap is reached. It returns hit or miss, a fault flag, the frame and the number of elements it visited.

Memory access goes through a plain read port that keeps exactly one read in flight. The response may arrive any number of cycles after the request.

A build parameter chooses between two element layouts:

- **Flat:** one element maps one page.
- **Clustered:** one element covers sixteen consecutive pages. Its tag is the VPN without its low four bits, and those four bits pick one of sixteen frame slots inside the element.

Creating, removing and allocating elements is left to software.

Top module: `hpt_chain_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of every lookup goes to the address equal to the bucket index. With H = VPN_W/2 and B = BUCKET_BITS, the bucket index is tag bits [H+B-1:H] XOR tag bits [B-1:0]. In flat mode the tag is the VPN. In clustered mode the tag is the VPN shifted right by 4.
- R3: The element layout is fixed:
  - bits [PTR_W-1:0] hold the next pointer;
  - bits [PTR_W+VPN_W-1:PTR_W] hold the tag;
  - frame slot i sits at bits [PTR_W+VPN_W+(i+1)*PFN_W-1 : PTR_W+VPN_W+i*PFN_W].
  
  When an element's tag equals the request's tag, the response reports a hit with that element's frame.
- R4: An element that does not match and has a next pointer of 0 ends the walk. The response is a miss with no fault.
- R5: A bucket whose head pointer is 0 gives a miss with 0 steps, after exactly one memory read. The head pointer is the low PTR_W bits of the bucket word.
- R6: `rsp_steps` equals the number of chain elements read. Each lookup issues exactly `rsp_steps + 1` memory reads, counting the bucket read.
- R7: Suppose the MAX_STEPS-th element read neither matches nor ends the chain. Then the lookup ends with a fault, no hit, and `rsp_steps` equal to MAX_STEPS. A cyclic chain therefore always terminates.
- R8: In clustered mode, a hit returns frame slot VPN[3:0] of the matching element. In flat mode, slot 0 is always used.
- R9: The block issues a new memory read only after the previous read has returned. `req_ready` is 0 from the cycle after a request is accepted until the response has been given.
- R10: Each accepted request produces exactly one `rsp_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | A matching element was found |
| rsp_fault | output | 1 | The step cap was reached |
| rsp_pfn | output | PFN_W | Frame from the matching element |
| rsp_steps | output | STEP_W | Number of chain elements read |
| mem_req_valid | output | 1 | Read request strobe |
| mem_req_addr | output | PTR_W | Read address (bucket index or element pointer) |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | ELEM_W | Element word or bucket word |

## Verification
The bench sweeps every VPN of an 8-bit configuration in both layouts. Memory latency varies from one to three cycles per address.

A fold that used the wrong half of the tag would show up as a wrong first read address. Dropping the low bits or choosing the wrong frame slot in clustered mode would return wrong frames in the sweep.

The bench turns one chain into a self-loop. A walker without a working cap would hang and trip the timeout. One whose cap is off by one would report the wrong step count.

The bench also empties one bucket. A walker that treated a zero head as an element address would read memory location 0 and report a step.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_ISSUE = 2'd1,
      WK_WAIT  = 2'd2
   } walk_state_t;

   localparam int CLUSTER_SLOTS = 16;
   localparam int CLUSTER_BITS  = 4;
endpackage

// File: rtl/hpt_key_hash.sv
`timescale 1ns/1ps
module hpt_key_hash #(
   parameter int VPN_W       = 20,
   parameter int BUCKET_BITS = 8,
   parameter bit CLUSTERED   = 1'b0
) (
   input  logic [VPN_W-1:0]       vpn,
   output logic [VPN_W-1:0]       tag,
   output logic [3:0]             slot,
   output logic [BUCKET_BITS-1:0] bucket
);
   localparam int HALF = VPN_W / 2;

   generate
      if (CLUSTERED) begin : g_clustered
         // Tag drops the in-cluster page index; that index selects the slot.
         assign tag  = {{hpt_pkg::CLUSTER_BITS{1'b0}}, vpn[VPN_W-1:hpt_pkg::CLUSTER_BITS]};
         assign slot = vpn[hpt_pkg::CLUSTER_BITS-1:0];
      end else begin : g_flat
         assign tag  = vpn;
         assign slot = 4'd0;
      end
   endgenerate

   // Fold the two halves of the tag together and keep the low bucket bits.
   assign bucket = tag[HALF +: BUCKET_BITS] ^ tag[0 +: BUCKET_BITS];
endmodule

// File: rtl/hpt_elem_match.sv
`timescale 1ns/1ps
module hpt_elem_match #(
   parameter int VPN_W     = 20,
   parameter int PFN_W     = 16,
   parameter int PTR_W     = 16,
   parameter bit CLUSTERED = 1'b0,
   parameter int ELEM_W    = 52
) (
   input  logic [VPN_W-1:0]  tag,
   input  logic [3:0]        slot,
   input  logic [ELEM_W-1:0] elem,
   output logic              hit,
   output logic [PFN_W-1:0]  pfn,
   output logic [PTR_W-1:0]  next
);
   localparam int TAG_LSB = PTR_W;
   localparam int FRM_LSB = PTR_W + VPN_W;

   logic tag_eq;

   assign next   = elem[PTR_W-1:0];
   assign tag_eq = (elem[TAG_LSB +: VPN_W] == tag);

   generate
      if (CLUSTERED) begin : g_clustered
         logic [PFN_W-1:0] frames [hpt_pkg::CLUSTER_SLOTS];
         for (genvar i = 0; i < hpt_pkg::CLUSTER_SLOTS; i++) begin : g_slot
            assign frames[i] = elem[FRM_LSB + i*PFN_W +: PFN_W];
         end
         assign pfn = frames[slot];
         assign hit = tag_eq;
      end else begin : g_flat
         assign pfn = elem[FRM_LSB +: PFN_W];
         assign hit = tag_eq && (slot == 4'd0);
      end
   endgenerate
endmodule

// File: rtl/hpt_chain_walker.sv
`timescale 1ns/1ps
module hpt_chain_walker #(
   parameter int VPN_W       = 20,
   parameter int PFN_W       = 16,
   parameter int PTR_W       = 16,
   parameter int BUCKET_BITS = 8,
   parameter int MAX_STEPS   = 32,
   parameter bit CLUSTERED   = 1'b0,
   localparam int NSLOT      = CLUSTERED ? hpt_pkg::CLUSTER_SLOTS : 1,
   localparam int ELEM_W     = PTR_W + VPN_W + NSLOT * PFN_W,
   localparam int STEP_W     = $clog2(MAX_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_fault,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [STEP_W-1:0] rsp_steps,
   output logic              mem_req_valid,
   output logic [PTR_W-1:0]  mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [ELEM_W-1:0] mem_rsp_data
);
   import hpt_pkg::*;

   initial begin
      assert (VPN_W % 2 == 0) else $fatal(1, "VPN_W must be even");
      assert (BUCKET_BITS >= 1 && BUCKET_BITS <= VPN_W / 2) else $fatal(1, "BUCKET_BITS out of range");
      assert (PTR_W > BUCKET_BITS) else $fatal(1, "PTR_W must exceed BUCKET_BITS");
      assert (MAX_STEPS >= 1) else $fatal(1, "MAX_STEPS must be positive");
      assert (!CLUSTERED || VPN_W >= 8) else $fatal(1, "clustered mode needs VPN_W >= 8");
   end

   walk_state_t       state;
   logic              at_head;
   logic [PTR_W-1:0]  cur_ptr;
   logic [STEP_W-1:0] steps;
   logic [VPN_W-1:0]  vpn_q;

   logic [VPN_W-1:0]       tag;
   logic [3:0]             slot;
   logic [BUCKET_BITS-1:0] bucket;
   logic                   e_hit;
   logic [PFN_W-1:0]       e_pfn;
   logic [PTR_W-1:0]       e_next;

   hpt_key_hash #(
      .VPN_W(VPN_W), .BUCKET_BITS(BUCKET_BITS), .CLUSTERED(CLUSTERED)
   ) u_hash (
      .vpn(vpn_q), .tag(tag), .slot(slot), .bucket(bucket)
   );

   hpt_elem_match #(
      .VPN_W(VPN_W), .PFN_W(PFN_W), .PTR_W(PTR_W),
      .CLUSTERED(CLUSTERED), .ELEM_W(ELEM_W)
   ) u_match (
      .tag(tag), .slot(slot), .elem(mem_rsp_data),
      .hit(e_hit), .pfn(e_pfn), .next(e_next)
   );

   assign req_ready     = (state == WK_IDLE);
   assign mem_req_valid = (state == WK_ISSUE);
   assign mem_req_addr  = at_head ? PTR_W'(bucket) : cur_ptr;

   // Decision taken when a read returns.
   logic [STEP_W-1:0] steps_inc;
   logic              fin, fin_hit, fin_fault, follow;

   assign steps_inc = steps + 1'b1;

   always_comb begin
      fin       = 1'b0;
      fin_hit   = 1'b0;
      fin_fault = 1'b0;
      follow    = 1'b0;
      if (state == WK_WAIT && mem_rsp_valid) begin
         if (at_head) begin
            if (e_next == '0) fin = 1'b1;
            else              follow = 1'b1;
         end else if (e_hit) begin
            fin     = 1'b1;
            fin_hit = 1'b1;
         end else if (e_next == '0) begin
            fin = 1'b1;
         end else if (steps_inc == STEP_W'(MAX_STEPS)) begin
            fin       = 1'b1;
            fin_fault = 1'b1;
         end else begin
            follow = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= WK_IDLE;
         at_head   <= 1'b0;
         cur_ptr   <= '0;
         steps     <= '0;
         vpn_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_pfn   <= '0;
         rsp_steps <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state)
            WK_IDLE: begin
               if (req_valid) begin
                  vpn_q   <= req_vpn;
                  at_head <= 1'b1;
                  steps   <= '0;
                  state   <= WK_ISSUE;
               end
            end
            WK_ISSUE: state <= WK_WAIT;
            WK_WAIT: begin
               if (mem_rsp_valid && !at_head) steps <= steps_inc;
               if (follow) begin
                  cur_ptr <= e_next;
                  at_head <= 1'b0;
                  state   <= WK_ISSUE;
               end else if (fin) begin
                  state     <= WK_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_hit   <= fin_hit;
                  rsp_fault <= fin_fault;
                  rsp_pfn   <= fin_hit ? e_pfn : '0;
                  rsp_steps <= at_head ? '0 : steps_inc;
               end
            end
            default: state <= WK_IDLE;
         endcase
      end
   end

   assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |=> !mem_req_valid);
   assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_no_early_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!rsp_valid && !req_ready));
   assert_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (!rsp_hit && rsp_steps == STEP_W'(MAX_STEPS)));
   assert_hit_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_steps != '0 && !rsp_fault));
   assert_no_read_on_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_req_valid);
endmodule

// File: tb/hpt_chain_walker_tb.sv
`timescale 1ns/1ps
module hpt_chain_walker_tb;
   localparam int VW = 8, FW = 8, PW = 8, BB = 2, MS = 8, SW = 4;
   localparam int EWF = PW + VW + FW;
   localparam int EWC = PW + VW + 16 * FW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int errors = 0;
   int checks = 0;

   // flat instance signals
   logic f_req_valid = 1'b0;
   logic [VW-1:0] f_req_vpn = '0;
   logic f_req_ready, f_rsp_valid, f_rsp_hit, f_rsp_fault;
   logic [FW-1:0] f_rsp_pfn;
   logic [SW-1:0] f_rsp_steps;
   logic f_mreq;
   logic [PW-1:0] f_maddr;
   logic f_mrsp = 1'b0;
   logic [EWF-1:0] f_mdata = '0;

   // clustered instance signals
   logic c_req_valid = 1'b0;
   logic [VW-1:0] c_req_vpn = '0;
   logic c_req_ready, c_rsp_valid, c_rsp_hit, c_rsp_fault;
   logic [FW-1:0] c_rsp_pfn;
   logic [SW-1:0] c_rsp_steps;
   logic c_mreq;
   logic [PW-1:0] c_maddr;
   logic c_mrsp = 1'b0;
   logic [EWC-1:0] c_mdata = '0;

   hpt_chain_walker #(.VPN_W(VW), .PFN_W(FW), .PTR_W(PW), .BUCKET_BITS(BB),
                      .MAX_STEPS(MS), .CLUSTERED(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(f_req_valid), .req_vpn(f_req_vpn),
      .req_ready(f_req_ready), .rsp_valid(f_rsp_valid), .rsp_hit(f_rsp_hit),
      .rsp_fault(f_rsp_fault), .rsp_pfn(f_rsp_pfn), .rsp_steps(f_rsp_steps),
      .mem_req_valid(f_mreq), .mem_req_addr(f_maddr),
      .mem_rsp_valid(f_mrsp), .mem_rsp_data(f_mdata));

   hpt_chain_walker #(.VPN_W(VW), .PFN_W(FW), .PTR_W(PW), .BUCKET_BITS(BB),
                      .MAX_STEPS(MS), .CLUSTERED(1'b1)) u_dut_clu (
      .clk(clk), .rst_n(rst_n), .req_valid(c_req_valid), .req_vpn(c_req_vpn),
      .req_ready(c_req_ready), .rsp_valid(c_rsp_valid), .rsp_hit(c_rsp_hit),
      .rsp_fault(c_rsp_fault), .rsp_pfn(c_rsp_pfn), .rsp_steps(c_rsp_steps),
      .mem_req_valid(c_mreq), .mem_req_addr(c_maddr),
      .mem_rsp_valid(c_mrsp), .mem_rsp_data(c_mdata));

   logic [EWF-1:0] mf [256];
   logic [EWC-1:0] mc [256];

   // memory responders: latency 1..3 cycles depending on address
   int f_nreq = 0, f_mark = 0, f_overlap = 0, f_cnt = 0;
   logic f_busy = 1'b0;
   logic [PW-1:0] f_a = '0, f_first = '0;
   always @(posedge clk) begin
      f_mrsp <= 1'b0;
      if (f_mreq) begin
         if (f_busy) f_overlap <= f_overlap + 1;
         if (f_nreq == f_mark) f_first <= f_maddr;
         f_nreq <= f_nreq + 1;
         f_busy <= 1'b1;
         f_a    <= f_maddr;
         f_cnt  <= 1 + int'(f_maddr % 3);
      end else if (f_busy) begin
         if (f_cnt == 1) begin
            f_busy  <= 1'b0;
            f_mrsp  <= 1'b1;
            f_mdata <= mf[f_a];
         end else f_cnt <= f_cnt - 1;
      end
   end

   int c_nreq = 0, c_mark = 0, c_overlap = 0, c_cnt = 0;
   logic c_busy = 1'b0;
   logic [PW-1:0] c_a = '0, c_first = '0;
   always @(posedge clk) begin
      c_mrsp <= 1'b0;
      if (c_mreq) begin
         if (c_busy) c_overlap <= c_overlap + 1;
         if (c_nreq == c_mark) c_first <= c_maddr;
         c_nreq <= c_nreq + 1;
         c_busy <= 1'b1;
         c_a    <= c_maddr;
         c_cnt  <= 1 + int'(c_maddr % 3);
      end else if (c_busy) begin
         if (c_cnt == 1) begin
            c_busy  <= 1'b0;
            c_mrsp  <= 1'b1;
            c_mdata <= mc[c_a];
         end else c_cnt <= c_cnt - 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [1:0] fold(input logic [7:0] t);
      return t[5:4] ^ t[1:0];
   endfunction

   task automatic ref_walk(input bit sel, input logic [7:0] v, output bit h, output bit f,
                           output logic [7:0] pfn, output int st, output logic [1:0] b);
      logic [7:0] t, p, nxt;
      t = sel ? {4'b0, v[7:4]} : v;
      b = fold(t);
      p = sel ? mc[b][7:0] : mf[b][7:0];
      h = 0; f = 0; pfn = '0; st = 0;
      while (p != 0) begin
         st++;
         if (sel) begin
            nxt = mc[p][7:0];
            if (mc[p][15:8] == t) begin h = 1; pfn = mc[p][16 + 8*int'(v[3:0]) +: 8]; break; end
         end else begin
            nxt = mf[p][7:0];
            if (mf[p][15:8] == t) begin h = 1; pfn = mf[p][23:16]; break; end
         end
         if (nxt == 0) break;
         if (st == MS) begin f = 1; break; end
         p = nxt;
      end
   endtask

   int hits = 0, faults = 0, empties = 0;

   task automatic lookup(input bit sel, input logic [7:0] v);
      bit eh, ef;
      logic [7:0] ep;
      int es, n0, wait_n;
      logic [1:0] eb;
      bit rv, rh, rf;
      logic [7:0] rp;
      int rs, reads;
      ref_walk(sel, v, eh, ef, ep, es, eb);
      n0 = sel ? c_nreq : f_nreq;
      if (sel) c_mark = n0; else f_mark = n0;
      @(negedge clk);
      wait_n = 0;
      while (!(sel ? c_req_ready : f_req_ready) && wait_n < 50) begin @(negedge clk); wait_n++; end
      if (sel) begin c_req_valid = 1; c_req_vpn = v; end
      else     begin f_req_valid = 1; f_req_vpn = v; end
      @(negedge clk);
      c_req_valid = 0; f_req_valid = 0;
      chk(!(sel ? c_req_ready : f_req_ready), "R9 busy while walking", 1, 0);
      wait_n = 0;
      rv = sel ? c_rsp_valid : f_rsp_valid;
      while (!rv && wait_n < 400) begin
         @(negedge clk); wait_n++;
         rv = sel ? c_rsp_valid : f_rsp_valid;
      end
      chk(rv, "R10 response arrives", int'(rv), 1);
      rh = sel ? c_rsp_hit : f_rsp_hit;
      rf = sel ? c_rsp_fault : f_rsp_fault;
      rp = sel ? c_rsp_pfn : f_rsp_pfn;
      rs = int'(sel ? c_rsp_steps : f_rsp_steps);
      reads = (sel ? c_nreq : f_nreq) - n0;
      chk(rh == eh, sel ? "R8 clustered hit" : "R3 hit flag", int'(rh), int'(eh));
      chk(rf == ef, "R7 fault flag", int'(rf), int'(ef));
      if (eh) chk(rp == ep, sel ? "R8 slot frame" : "R3 frame", int'(rp), int'(ep));
      if (!eh && !ef) chk(!rh && !rf, "R4 plain miss", int'(rh), 0);
      chk(rs == es, "R6 step count", rs, es);
      chk(reads == es + 1, "R6 read count", reads, es + 1);
      chk((sel ? c_first : f_first) == PW'(eb), "R2 bucket address",
          int'(sel ? c_first : f_first), int'(eb));
      if (es == 0) chk(reads == 1, "R5 empty bucket single read", reads, 1);
      chk((sel ? c_overlap : f_overlap) == 0, "R9 single outstanding",
          sel ? c_overlap : f_overlap, 0);
      @(negedge clk);
      rv = sel ? c_rsp_valid : f_rsp_valid;
      chk(!rv, "R10 one-cycle pulse", int'(rv), 0);
      if (rh) hits++;
      if (rf) faults++;
      if (es == 0) empties++;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] nf, v, p;
      logic [1:0] b;
      logic [EWC-1:0] e;
      for (int i = 0; i < 256; i++) begin mf[i] = '0; mc[i] = '0; end
      // flat table: pages 0,11,22,... pushed at chain heads
      nf = 8'd4;
      for (int k = 0; k < 24; k++) begin
         v = 8'(k * 11);
         b = fold(v);
         mf[nf] = {8'((int'(v) * 3 + 1) & 255), v, mf[b][7:0]};
         mf[b]  = {16'h0, nf};
         nf++;
      end
      // clustered table: clusters t with t%3 != 2
      nf = 8'd4;
      for (int t = 0; t < 16; t++) begin
         if (t % 3 != 2) begin
            b = fold(8'(t));
            e = '0;
            for (int s = 0; s < 16; s++) e[16 + 8*s +: 8] = 8'(t * 16 + s) ^ 8'h5A;
            e[15:8] = 8'(t);
            e[7:0]  = mc[b][7:0];
            mc[nf]  = e;
            mc[b]   = {{(EWC-8){1'b0}}, nf};
            nf++;
         end
      end

      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(f_req_ready && c_req_ready, "R1 ready after reset", int'(f_req_ready), 1);
      chk(!f_rsp_valid && !c_rsp_valid, "R1 no response in reset", int'(f_rsp_valid), 0);
      chk(!f_mreq && !c_mreq, "R1 no read in reset", int'(f_mreq), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      hits = 0; faults = 0;
      for (int i = 0; i < 256; i++) lookup(1'b0, 8'(i));
      chk(hits == 24, "R3 flat sweep hit total", hits, 24);
      chk(faults == 0, "R4 flat sweep no faults", faults, 0);

      hits = 0;
      for (int i = 0; i < 256; i++) lookup(1'b1, 8'(i));
      chk(hits == 176, "R8 clustered sweep hit total", hits, 176);

      // make bucket 0 cyclic and empty bucket 1
      p = mf[0][7:0];
      mf[p][7:0] = p;
      mf[1] = '0;
      hits = 0; faults = 0; empties = 0;
      for (int i = 0; i < 256; i++) lookup(1'b0, 8'(i));
      chk(faults == 63, "R7 cyclic chain faults", faults, 63);
      chk(empties == 64, "R5 empty bucket misses", empties, 64);

      summary();
      $finish;
   end
endmodule